// File: doc/BRIEF.md
# Waveform Timer Channel

One counter channel that drives two output pins, A and B, as waveforms. A synchronous count input is edge-detected, optionally inverted and gated, and each qualified edge is one tick. On each tick the counter steps according to one of four counting shapes. Matches against three compare values (RA, RB, RC), an edge on a selectable external event line, and a software trigger each set, clear or invert the pins according to a 2-bit action code per event and per pin.

The channel has command pulses for clock enable, clock disable and software trigger, and a 28-bit mode word. A status word holds event flags that stay set until a read strobe clears them. It also mirrors the clock-enabled state and both pins. The interrupt output is the masked OR of the event flags. Writing the commands and the mode word, and the address decoding, belong to the bus logic outside this block.

Top module: `wavetmr_chan`

## Requirements
- R1: After reset the count is 0, both pins are low, the clock-enabled state is off, every status bit is 0 and the interrupt is low.
- R2: The counter moves only on a counted tick while the clock is enabled (enable command sets it, disable command clears it) and the channel has been started; a trigger (software command or a qualified external event) makes the next counted tick load 0 and start the channel.
- R3: Mode bit 0 set counts falling edges of the count input instead of rising edges; mode bits [2:1] = 0 count ungated, 1..3 count only while external line 0..2 is high.
- R4: Shape 0 (mode bits [11:10] = 0) counts up and wraps from the all-ones value to 0, setting status bit 0 at the wrap.
- R5: Shape 2 counts up and returns to 0 on the tick after the count reaches RC, so one period lasts RC+1 ticks.
- R6: Shape 1 counts from 0 up to all-ones and back down; shape 3 does the same between 0 and RC; the direction turns at the top and at 0.
- R7: Pin A applies the code in mode bits [13:12] when the count reaches RA and [15:14] when it reaches RC; pin B applies [21:20] at RB and [23:22] at RC; code 0 keeps, 1 drives high, 2 drives low, 3 inverts.
- R8: Software trigger codes (A [19:18], B [27:26]) beat external event codes (A [17:16], B [25:24]), which beat RC codes, which beat RA/RB codes; an event coded 0 leaves the pin to the next event in that order.
- R9: Mode bits [8:7] pick the event line (0 = event pin input, 1..3 = external line 0..2) and bits [6:5] its edge (0 none, 1 rising, 2 falling, 3 both); each detected edge sets status bit 7 and, with mode bit 9 set, acts as a trigger.
- R10: With mode bit 3 set an RC match stops the counter until the next trigger while the clock stays enabled; with mode bit 4 set an RC match turns the clock-enabled state off.
- R11: Status bits 0, 2, 3, 4 and 7 (overflow, RA, RB, RC match, external event) stay set until the read strobe clears them; bits 8, 9, 10 mirror clock enabled, pin A and pin B; the interrupt is high while any set bit in 0..7 has its mask bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_clk_i | input | 1 | Count input, synchronous level, edge-detected |
| xclk_i | input | 3 | External lines used for gating and as event sources |
| evt_pin_i | input | 1 | Event pin input (event source 0) |
| cmd_en_i | input | 1 | Clock enable command pulse |
| cmd_dis_i | input | 1 | Clock disable command pulse |
| cmd_trg_i | input | 1 | Software trigger command pulse |
| mode_i | input | 28 | Mode word |
| ra_i | input | CNT_W | Compare value A |
| rb_i | input | CNT_W | Compare value B |
| rc_i | input | CNT_W | Compare value C, also the period limit |
| irq_mask_i | input | 8 | Interrupt mask over status bits 0..7 |
| stat_rd_i | input | 1 | Status read strobe, clears event flags |
| cnt_o | output | CNT_W | Counter value |
| pin_a_o | output | 1 | Waveform pin A |
| pin_b_o | output | 1 | Waveform pin B |
| status_o | output | 16 | Status word |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume the count input and the event lines are low when reset is released, because the edge detectors start from a low sample. They also assume that a mode word which changes the clock polarity is written while the count input is low. The stimulus changes mode fields only while the count input is low and the lines are quiet. It spaces count pulses two cycles apart, so every compare match is seen and acted on before the next tick.

// File: rtl/wavetmr_pkg.sv
package wavetmr_pkg;

  typedef enum logic [1:0] {ACT_NONE, ACT_SET, ACT_CLR, ACT_TGL} act_e;
  typedef enum logic [1:0] {SHP_UP, SHP_UPDN, SHP_UP_RC, SHP_UPDN_RC} shape_e;

  typedef struct packed {
    act_e        b_sw;
    act_e        b_ev;
    act_e        b_rc;
    act_e        b_cmp;
    act_e        a_sw;
    act_e        a_ev;
    act_e        a_rc;
    act_e        a_cmp;
    shape_e      shape;
    logic        ev_trg_en;
    logic [1:0]  ev_src;
    logic [1:0]  ev_edge;
    logic        dis_rc;
    logic        stop_rc;
    logic [1:0]  gate;
    logic        clk_inv;
  } mode_t;

  localparam int MODE_W  = $bits(mode_t);
  localparam int NEV     = 8;
  localparam int ST_OVF  = 0;
  localparam int ST_CPA  = 2;
  localparam int ST_CPB  = 3;
  localparam int ST_CPC  = 4;
  localparam int ST_ETRG = 7;

  // Result of one pin action on the current pin level.
  function automatic logic act_apply(logic cur, act_e a);
    case (a)
      ACT_SET: return 1'b1;
      ACT_CLR: return 1'b0;
      ACT_TGL: return ~cur;
      default: return cur;
    endcase
  endfunction

  // Highest-priority event with a non-zero code wins.
  function automatic act_e act_pick(logic sw, logic ev, logic rc, logic cmp,
                                    act_e c_sw, act_e c_ev, act_e c_rc, act_e c_cmp);
    if (sw && c_sw != ACT_NONE) return c_sw;
    if (ev && c_ev != ACT_NONE) return c_ev;
    if (rc && c_rc != ACT_NONE) return c_rc;
    if (cmp && c_cmp != ACT_NONE) return c_cmp;
    return ACT_NONE;
  endfunction

  // Edge code: bit 0 selects rising, bit 1 selects falling.
  function automatic logic edge_hit(logic rise, logic fall, logic [1:0] code);
    return (code[0] & rise) | (code[1] & fall);
  endfunction

endpackage

// File: rtl/wavetmr_edge.sv
module wavetmr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
  assign fall_o = ~sig_i & sig_q;

  p_edge_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/wavetmr_counter.sv
module wavetmr_counter
  import wavetmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             dis_i,
  input  logic             trg_ext_i,
  input  logic             trg_auto_i,
  input  logic             stop_i,
  input  logic             off_i,
  input  shape_e           shape_i,
  input  logic [CNT_W-1:0] top_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             upd_o,
  output logic             ovf_o,
  output logic             clk_on_o
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic             dn_q, run_q, pend_q, step;
  logic [CNT_W-1:0] lim;
  logic [CNT_W:0]   nxt;

  // Next {direction, count} for one step of the selected shape.
  function automatic logic [CNT_W:0] step_val(logic [CNT_W-1:0] c, logic dn,
                                              logic pend, logic updn,
                                              logic [CNT_W-1:0] limit);
    if (pend)          return {1'b0, {CNT_W{1'b0}}};
    if (!updn)         return {1'b0, c + 1'b1};
    if (!dn)           return (c >= limit) ? {1'b1, c - 1'b1} : {1'b0, c + 1'b1};
    if (c == '0)       return {1'b0, c + 1'b1};
    return {1'b1, c - 1'b1};
  endfunction

  assign lim   = (shape_i == SHP_UPDN_RC) ? top_i : MAXV;
  assign step  = tick_i & clk_on_o & ~stop_i & ~off_i & (run_q | pend_q);
  assign nxt   = step_val(cnt_o, dn_q, pend_q, shape_i[0], lim);
  assign ovf_o = step & ~pend_q & ~dn_q & (cnt_o == MAXV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o    <= '0;
      dn_q     <= 1'b0;
      run_q    <= 1'b0;
      pend_q   <= 1'b0;
      upd_o    <= 1'b0;
      clk_on_o <= 1'b0;
    end else begin
      upd_o <= step;
      if (step) begin
        cnt_o <= nxt[CNT_W-1:0];
        dn_q  <= nxt[CNT_W];
      end
      if (stop_i)             run_q <= 1'b0;
      else if (step && pend_q) run_q <= 1'b1;
      pend_q <= trg_ext_i | (trg_auto_i & ~stop_i) | (pend_q & ~step & ~stop_i);
      if (dis_i || off_i) clk_on_o <= 1'b0;
      else if (en_i)      clk_on_o <= 1'b1;
    end
  end

  p_off_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_on_o |=> $stable(cnt_o));
  p_trig_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && pend_q) |=> (cnt_o == '0));
  p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !run_q);
  p_dis_rc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    off_i |=> !clk_on_o);

endmodule

// File: rtl/wavetmr_pin.sv
module wavetmr_pin
  import wavetmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ev_sw_i,
  input  logic ev_ext_i,
  input  logic ev_rc_i,
  input  logic ev_cmp_i,
  input  act_e a_sw_i,
  input  act_e a_ext_i,
  input  act_e a_rc_i,
  input  act_e a_cmp_i,
  output logic pin_o
);
  act_e win;

  assign win = act_pick(ev_sw_i, ev_ext_i, ev_rc_i, ev_cmp_i,
                        a_sw_i, a_ext_i, a_rc_i, a_cmp_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_o <= 1'b0;
    else        pin_o <= act_apply(pin_o, win);
  end

  p_sw_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sw_i && a_sw_i == ACT_SET) |=> pin_o);
  p_cmp_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmp_i && !ev_sw_i && !ev_ext_i && !ev_rc_i && a_cmp_i == ACT_TGL)
      |=> (pin_o != $past(pin_o)));

endmodule

// File: rtl/wavetmr_status.sv
module wavetmr_status
  import wavetmr_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] evt_i,
  input  logic           rd_i,
  input  logic [NEV-1:0] mask_i,
  output logic [NEV-1:0] flags_o,
  output logic           irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_o <= '0;
    else        flags_o <= (rd_i ? '0 : flags_o) | evt_i;
  end

  assign irq_o = |(flags_o & mask_i);

  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));
  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && evt_i == '0) |=> (flags_o == '0));

endmodule

// File: rtl/wavetmr_chan.sv
module wavetmr_chan
  import wavetmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_clk_i,
  input  logic [2:0]       xclk_i,
  input  logic             evt_pin_i,
  input  logic             cmd_en_i,
  input  logic             cmd_dis_i,
  input  logic             cmd_trg_i,
  input  logic [27:0]      mode_i,
  input  logic [CNT_W-1:0] ra_i,
  input  logic [CNT_W-1:0] rb_i,
  input  logic [CNT_W-1:0] rc_i,
  input  logic [7:0]       irq_mask_i,
  input  logic             stat_rd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pin_a_o,
  output logic             pin_b_o,
  output logic [15:0]      status_o,
  output logic             irq_o
);
  localparam int NPIN = 2;

  mode_t          m;
  logic [3:0]     gate_vec, src_vec;
  logic           ck_rise, ck_fall, ev_rise, ev_fall;
  logic           tick, ev_hit, upd, ovf, clk_on;
  logic           hit_a, hit_b, hit_c;
  logic           trg_ext, trg_auto;
  logic [NEV-1:0] evts, flags;

  assign m        = mode_t'(mode_i);
  assign gate_vec = {xclk_i, 1'b1};
  assign src_vec  = {xclk_i, evt_pin_i};

  wavetmr_edge u_ck_edge (.clk(clk), .rst_n(rst_n), .sig_i(cnt_clk_i),
                          .rise_o(ck_rise), .fall_o(ck_fall));
  wavetmr_edge u_ev_edge (.clk(clk), .rst_n(rst_n), .sig_i(src_vec[m.ev_src]),
                          .rise_o(ev_rise), .fall_o(ev_fall));

  assign tick     = (m.clk_inv ? ck_fall : ck_rise) & gate_vec[m.gate];
  assign ev_hit   = edge_hit(ev_rise, ev_fall, m.ev_edge);
  assign hit_a    = upd & (cnt_o == ra_i);
  assign hit_b    = upd & (cnt_o == rb_i);
  assign hit_c    = upd & (cnt_o == rc_i);
  assign trg_ext  = cmd_trg_i | (m.ev_trg_en & ev_hit);
  assign trg_auto = hit_c & (m.shape == SHP_UP_RC);

  wavetmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .en_i(cmd_en_i), .dis_i(cmd_dis_i),
    .trg_ext_i(trg_ext), .trg_auto_i(trg_auto),
    .stop_i(hit_c & m.stop_rc), .off_i(hit_c & m.dis_rc),
    .shape_i(m.shape), .top_i(rc_i),
    .cnt_o(cnt_o), .upd_o(upd), .ovf_o(ovf), .clk_on_o(clk_on));

  // Per-pin event sets: index 0 is pin A, index 1 is pin B.
  logic pin_cmp [NPIN];
  act_e c_sw [NPIN], c_ev [NPIN], c_rc [NPIN], c_cmp [NPIN];
  logic pin_q [NPIN];

  always_comb begin
    pin_cmp[0] = hit_a;  pin_cmp[1] = hit_b;
    c_sw[0]  = m.a_sw;   c_sw[1]  = m.b_sw;
    c_ev[0]  = m.a_ev;   c_ev[1]  = m.b_ev;
    c_rc[0]  = m.a_rc;   c_rc[1]  = m.b_rc;
    c_cmp[0] = m.a_cmp;  c_cmp[1] = m.b_cmp;
  end

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    wavetmr_pin u_pin (
      .clk(clk), .rst_n(rst_n),
      .ev_sw_i(cmd_trg_i), .ev_ext_i(ev_hit), .ev_rc_i(hit_c), .ev_cmp_i(pin_cmp[g]),
      .a_sw_i(c_sw[g]), .a_ext_i(c_ev[g]), .a_rc_i(c_rc[g]), .a_cmp_i(c_cmp[g]),
      .pin_o(pin_q[g]));
  end

  assign pin_a_o = pin_q[0];
  assign pin_b_o = pin_q[1];

  always_comb begin
    evts          = '0;
    evts[ST_OVF]  = ovf;
    evts[ST_CPA]  = hit_a;
    evts[ST_CPB]  = hit_b;
    evts[ST_CPC]  = hit_c;
    evts[ST_ETRG] = ev_hit;
  end

  wavetmr_status u_st (.clk(clk), .rst_n(rst_n), .evt_i(evts), .rd_i(stat_rd_i),
                       .mask_i(irq_mask_i), .flags_o(flags), .irq_o(irq_o));

  assign status_o = {5'b0, pin_b_o, pin_a_o, clk_on, flags};

  p_ovf_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> status_o[ST_OVF]);
  p_ev_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> status_o[ST_ETRG]);

endmodule

// File: tb/wavetmr_chan_tb.sv
module wavetmr_chan_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cnt_clk_i = 1'b0;
  logic [2:0]   xclk_i = '0;
  logic         evt_pin_i = 1'b0;
  logic         cmd_en_i = 1'b0, cmd_dis_i = 1'b0, cmd_trg_i = 1'b0;
  logic [27:0]  mode_i = '0;
  logic [W-1:0] ra_i = '0, rb_i = '0, rc_i = '0;
  logic [7:0]   irq_mask_i = '0;
  logic         stat_rd_i = 1'b0;
  logic [W-1:0] cnt_o;
  logic         pin_a_o, pin_b_o, irq_o;
  logic [15:0]  status_o;

  int nchk = 0, nerr = 0;
  bit done = 0;

  wavetmr_chan #(.CNT_W(W)) u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    cyc(3);
  endtask

  task automatic tick(int n);
    repeat (n) begin
      @(negedge clk) cnt_clk_i = 1'b1;
      @(negedge clk) cnt_clk_i = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cnt_clk_i = 0; xclk_i = 0; evt_pin_i = 0;
    cmd_en_i = 0; cmd_dis_i = 0; cmd_trg_i = 0; mode_i = '0;
    ra_i = '0; rb_i = '0; rc_i = '0; irq_mask_i = '0; stat_rd_i = 0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic pulse_en();  @(negedge clk) cmd_en_i = 1;  @(negedge clk) cmd_en_i = 0;  endtask
  task automatic pulse_dis(); @(negedge clk) cmd_dis_i = 1; @(negedge clk) cmd_dis_i = 0; endtask
  task automatic pulse_trg(); @(negedge clk) cmd_trg_i = 1; @(negedge clk) cmd_trg_i = 0; endtask
  task automatic pulse_rd();  @(negedge clk) stat_rd_i = 1; @(negedge clk) stat_rd_i = 0; endtask

  // enable, trigger and one tick: counter at 0 and running
  task automatic start();
    pulse_en(); pulse_trg(); tick(1); settle();
  endtask

  task automatic set_src(int s, logic v);
    @(negedge clk);
    if (s == 0) evt_pin_i = v;
    else        xclk_i[s-1] = v;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1 count", int'(cnt_o), 0);
    chk("R1 pin A", int'(pin_a_o), 0);
    chk("R1 pin B", int'(pin_b_o), 0);
    chk("R1 status", int'(status_o), 0);
    chk("R1 irq", int'(irq_o), 0);

    // R2 enable, start, disable
    do_reset();
    pulse_en(); tick(3); settle();
    chk("R2 enabled but not started", int'(cnt_o), 0);
    do_reset();
    pulse_trg(); tick(3); settle();
    chk("R2 started but clock off", int'(cnt_o), 0);
    pulse_en(); tick(1); tick(4); settle();
    chk("R2 counting", int'(cnt_o), 4);
    pulse_dis(); tick(3); settle();
    chk("R2 after disable", int'(cnt_o), 4);

    // R3 gating and inversion
    do_reset();
    mode_i[2:1] = 2'd1;
    xclk_i[0] = 1'b1;
    start(); tick(2); settle();
    chk("R3 gate open", int'(cnt_o), 2);
    xclk_i[0] = 1'b0; tick(3); settle();
    chk("R3 gate closed", int'(cnt_o), 2);
    xclk_i[0] = 1'b1; tick(1); settle();
    chk("R3 gate reopened", int'(cnt_o), 3);
    mode_i[2:1] = 2'd0; mode_i[0] = 1'b1;
    @(negedge clk) cnt_clk_i = 1'b1; settle();
    chk("R3 inverted rising ignored", int'(cnt_o), 3);
    @(negedge clk) cnt_clk_i = 1'b0; settle();
    chk("R3 inverted falling counts", int'(cnt_o), 4);

    // R4 wrap and overflow flag
    do_reset();
    start(); tick(255); settle();
    chk("R4 top value", int'(cnt_o), 255);
    chk("R4 no overflow yet", int'(status_o[0]), 0);
    tick(1); settle();
    chk("R4 wrapped", int'(cnt_o), 0);
    chk("R4 overflow flag", int'(status_o[0]), 1);

    // R5 automatic restart at RC
    for (int rc = 2; rc <= 5; rc++) begin
      do_reset();
      mode_i[11:10] = 2'd2; rc_i = W'(rc);
      start();
      for (int k = 1; k <= 2 * rc + 3; k++) begin
        tick(1); settle();
        chk($sformatf("R5 rc=%0d k=%0d", rc, k), int'(cnt_o), k % (rc + 1));
      end
    end

    // R6 up/down between 0 and RC
    for (int rc = 2; rc <= 5; rc++) begin
      do_reset();
      mode_i[11:10] = 2'd3; rc_i = W'(rc);
      start();
      for (int k = 1; k <= 3 * rc + 1; k++) begin
        int p;
        tick(1); settle();
        p = k % (2 * rc);
        chk($sformatf("R6 rc=%0d k=%0d", rc, k), int'(cnt_o), (p <= rc) ? p : 2 * rc - p);
      end
    end
    // R6 shape 1 turns at all-ones
    do_reset();
    mode_i[11:10] = 2'd1; rc_i = W'(3);
    start(); tick(255); settle();
    chk("R6 shape1 top", int'(cnt_o), 255);
    tick(1); settle();
    chk("R6 shape1 turned", int'(cnt_o), 254);
    tick(254); settle();
    chk("R6 shape1 bottom", int'(cnt_o), 0);
    tick(1); settle();
    chk("R6 shape1 up again", int'(cnt_o), 1);

    // R7 compare actions on both pins
    do_reset();
    mode_i[11:10] = 2'd2; rc_i = 6; ra_i = 2; rb_i = 4;
    mode_i[13:12] = 2'd1; mode_i[15:14] = 2'd2;
    mode_i[21:20] = 2'd3; mode_i[23:22] = 2'd0;
    start();
    begin
      int v = 0; int pa = 0; int pb = 0;
      for (int k = 1; k <= 16; k++) begin
        v = (v == 6) ? 0 : v + 1;
        if (v == 2) pa = 1;
        if (v == 6) pa = 0;
        if (v == 4) pb = 1 - pb;
        tick(1); settle();
        chk($sformatf("R7 pin A k=%0d", k), int'(pin_a_o), pa);
        chk($sformatf("R7 pin B k=%0d", k), int'(pin_b_o), pb);
      end
    end

    // R8 priority
    do_reset();
    mode_i[19:18] = 2'd1; mode_i[17:16] = 2'd2;
    mode_i[8:7] = 2'd1; mode_i[6:5] = 2'd1;
    @(negedge clk) begin cmd_trg_i = 1; xclk_i[0] = 1; end
    @(negedge clk) cmd_trg_i = 0;
    settle();
    chk("R8 software over event", int'(pin_a_o), 1);
    mode_i[19:18] = 2'd0;
    @(negedge clk) xclk_i[0] = 0;
    settle();
    @(negedge clk) begin cmd_trg_i = 1; xclk_i[0] = 1; end
    @(negedge clk) cmd_trg_i = 0;
    settle();
    chk("R8 software code 0 defers to event", int'(pin_a_o), 0);
    do_reset();
    ra_i = 3; rb_i = 3; rc_i = 3;
    mode_i[15:14] = 2'd1; mode_i[13:12] = 2'd2;
    mode_i[23:22] = 2'd3; mode_i[21:20] = 2'd2;
    start(); tick(3); settle();
    chk("R8 RC over RA on pin A", int'(pin_a_o), 1);
    chk("R8 RC over RB on pin B", int'(pin_b_o), 1);

    // R9 event source and edge sweep
    for (int s = 0; s < 4; s++) begin
      for (int e = 0; e < 4; e++) begin
        int n;
        do_reset();
        mode_i[8:7] = 2'(s); mode_i[6:5] = 2'(e); mode_i[17:16] = 2'd3;
        n = (e & 1) + ((e >> 1) & 1);
        set_src(s, 1'b1); settle();
        set_src(s, 1'b0); settle();
        chk($sformatf("R9 pin A src=%0d edge=%0d", s, e), int'(pin_a_o), n % 2);
        chk($sformatf("R9 flag src=%0d edge=%0d", s, e), int'(status_o[7]), (n > 0) ? 1 : 0);
      end
    end
    do_reset();
    mode_i[9] = 1'b1; mode_i[8:7] = 2'd1; mode_i[6:5] = 2'd1;
    start(); tick(5); settle();
    chk("R9 before event trigger", int'(cnt_o), 5);
    set_src(1, 1'b1); settle();
    tick(1); settle();
    chk("R9 event trigger restarts", int'(cnt_o), 0);
    tick(2); settle();
    chk("R9 counts after restart", int'(cnt_o), 2);

    // R10 stop and disable on RC
    do_reset();
    rc_i = 3; mode_i[3] = 1'b1;
    start(); tick(8); settle();
    chk("R10 stopped at RC", int'(cnt_o), 3);
    chk("R10 clock still on", int'(status_o[8]), 1);
    pulse_trg(); tick(1); tick(2); settle();
    chk("R10 restart after trigger", int'(cnt_o), 2);
    do_reset();
    rc_i = 3; mode_i[4] = 1'b1;
    start(); tick(8); settle();
    chk("R10 disabled at RC", int'(cnt_o), 3);
    chk("R10 clock off", int'(status_o[8]), 0);

    // R11 status, read clear, mirrors, interrupt
    do_reset();
    ra_i = 1; rb_i = 2; rc_i = 3;
    start(); tick(3); settle();
    chk("R11 match flags", int'(status_o[4:2]), 7);
    chk("R11 irq masked", int'(irq_o), 0);
    irq_mask_i = 8'h08; cyc(1);
    chk("R11 irq unmasked", int'(irq_o), 1);
    pulse_rd(); settle();
    chk("R11 cleared by read", int'(status_o[7:0]), 0);
    chk("R11 irq after read", int'(irq_o), 0);
    mode_i[19:18] = 2'd1;
    pulse_trg(); settle();
    chk("R11 pin A mirror", int'(status_o[9]), 1);
    chk("R11 pin B mirror", int'(status_o[10]), 0);
    chk("R11 clock mirror", int'(status_o[8]), 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule